// File: doc/BRIEF.md
# Multi-Mode Digital Threshold Comparator

This block is the digital core of one comparator channel. Each cycle it compares a 12-bit sample code against threshold codes held in local registers. A 2-bit mode field selects one of four behaviours:

- a plain single-threshold compare;
- a hysteresis compare with separate rising and falling switching points;
- a latching compare, which falls out of hysteresis when one switching point can never be crossed;
- a window compare that reports when the sample leaves a band, with an optional latch on that report.

Software loads the registers through a simple write port. A per-channel strobe releases a latched result. Three outputs are produced: a pin value, a status flag that can always be read, and a window status bit meant for a general-purpose output selector.

Two state machines carry the state. The level machine (states LVL_CLEAR and LVL_SET) serves the normal and hysteresis modes:

- In normal mode it moves to LVL_SET when the sample is above the threshold, and to LVL_CLEAR otherwise.
- In hysteresis mode it moves from LVL_CLEAR to LVL_SET when the sample rises above margin-high.
- It moves from LVL_SET to LVL_CLEAR when the sample falls below margin-low, or on a strobe while the sample is not above margin-high.

The window machine (states WIN_INSIDE, WIN_OUTSIDE and WIN_HELD) serves window mode:

- When the latch is off, it moves between WIN_INSIDE and WIN_OUTSIDE as the sample leaves or re-enters the band.
- When the latch is on, leaving the band moves it to WIN_HELD.
- WIN_HELD returns to WIN_INSIDE only on a strobe while the sample is inside the band.

Both machines return to their cleared state (LVL_CLEAR, WIN_INSIDE) on reset and on any configuration write that changes the mode.

Top module: `thresh_cmp_chan`

## Requirements
- R1: While reset is low, and on the first cycles after it, cmp_pin_o, cmp_flag_o and win_stat_o are 0 and all registers read as zero (mode normal, output disabled, all codes 0).
- R2: In mode 2'b00 (and the spare code 2'b11), the raw result one clock edge after a sample is 1 exactly when sample_i is strictly greater than the threshold code; equality gives 0.
- R3: Config bit 2 (invert) flips cmp_flag_o and the driven pin value relative to the raw result.
- R4: Config bit 3 (output enable) gates the pin: when clear, cmp_pin_o is 0 while cmp_flag_o still follows the result.
- R5: In mode 2'b01 the result sets when sample_i > margin-high, clears when sample_i < margin-low, and holds between or at either code.
- R6: In mode 2'b01, a margin-low of zero makes a set result stick until a strobe, and a margin-high of full code (4095) keeps the result clear.
- R7: In mode 2'b01, a strobe on flag_clr_i clears the result, unless sample_i is above margin-high in that same cycle, in which case the result is set.
- R8: In mode 2'b10, win_stat_o is 1 when sample_i > margin-high or sample_i < margin-low and 0 inside (equality is inside), cmp_flag_o shows it (xor invert) and cmp_pin_o stays 0. Outside mode 2'b10, win_stat_o is 0.
- R9: In mode 2'b10 with config bit 4 (window latch) set, win_stat_o holds 1 after an excursion; a strobe clears it only when sample_i is inside the band in that cycle.
- R10: A configuration write that changes the mode returns both state machines to their cleared state at that edge.
- R11: Write port: wr_sel_i 0 selects config (mode in bits [1:0]), 1 the threshold, 2 margin-high, 3 margin-low; codes are taken from wr_data_i[15:4] and bits [3:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | 16 | Write data |
| flag_clr_i | input | 1 | Reset-flag strobe for latched results |
| sample_i | input | 12 | Input sample code |
| cmp_pin_o | output | 1 | Comparator pin value |
| cmp_flag_o | output | 1 | Comparator status flag |
| win_stat_o | output | 1 | Window status for the general-purpose output path |

## Verification
The bench builds the block with its default parameters: 12-bit codes in 16-bit registers. These values bring several boundaries within reach:

- the full code 4095 as an uncrossable margin-high;
- zero as an uncrossable margin-low;
- a non-zero low nibble in a threshold write, which must not move the compare point.

Samples sit exactly on each threshold as well as one code past it, so the strict comparisons and the hold band of both machines are checked at their edges.

// File: rtl/thresh_cmp_pkg.sv
`timescale 1ns/1ps
package thresh_cmp_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_HYST   = 2'b01,
        MODE_WINDOW = 2'b10,
        MODE_SPARE  = 2'b11
    } cmp_mode_e;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_THR  = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_LOW  = 2'd3
    } reg_sel_e;

    // Config word, low bits of the written data
    typedef struct packed {
        logic      win_latch;   // bit 4
        logic      out_en;      // bit 3
        logic      invert;      // bit 2
        cmp_mode_e mode;        // bits 1:0
    } cmp_cfg_t;

    typedef enum logic {
        LVL_CLEAR = 1'b0,
        LVL_SET   = 1'b1
    } lvl_state_e;

    typedef enum logic [1:0] {
        WIN_INSIDE  = 2'd0,
        WIN_OUTSIDE = 2'd1,
        WIN_HELD    = 2'd2
    } win_state_e;

endpackage

// File: rtl/thresh_cmp_regs.sv
`timescale 1ns/1ps
module thresh_cmp_regs
    import thresh_cmp_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output cmp_cfg_t          cfg_o,
    output logic [CODE_W-1:0] thr_o,
    output logic [CODE_W-1:0] high_o,
    output logic [CODE_W-1:0] low_o,
    output logic              restart_o
);

    localparam int LSB   = REG_W - CODE_W;
    localparam int NCODE = 3;
    localparam int CFG_W = $bits(cmp_cfg_t);

    cmp_cfg_t cfg_q;
    cmp_cfg_t cfg_new;

    assign cfg_new = cmp_cfg_t'(wr_data_i[CFG_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en_i && wr_sel_i == SEL_CFG) begin
            cfg_q <= cfg_new;
        end
    end

    // Three code registers: threshold, margin-high, margin-low (selects 1..3)
    for (genvar g = 0; g < NCODE; g++) begin : g_code
        logic [CODE_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en_i && wr_sel_i == 2'(g + 1)) begin
                q <= wr_data_i[REG_W-1:LSB];
            end
        end
    end

    assign cfg_o  = cfg_q;
    assign thr_o  = g_code[0].q;
    assign high_o = g_code[1].q;
    assign low_o  = g_code[2].q;

    // A config write that alters the mode restarts the state machines
    assign restart_o = wr_en_i && (wr_sel_i == SEL_CFG) && (cfg_new.mode != cfg_q.mode);

    logic unused_bits;
    assign unused_bits = ^{wr_data_i[LSB-1:0], wr_data_i[REG_W-1:CFG_W]};

endmodule

// File: rtl/thresh_cmp_level_fsm.sv
`timescale 1ns/1ps
module thresh_cmp_level_fsm
    import thresh_cmp_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  cmp_mode_e         mode_i,
    input  logic              strobe_i,
    input  logic [CODE_W-1:0] sample_i,
    input  logic [CODE_W-1:0] thr_i,
    input  logic [CODE_W-1:0] high_i,
    input  logic [CODE_W-1:0] low_i,
    output logic              set_o
);

    lvl_state_e state_q, state_d;

    logic above_thr, above_high, below_low;

    assign above_thr  = sample_i > thr_i;
    assign above_high = sample_i > high_i;
    assign below_low  = sample_i < low_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (restart_i) begin
            state_d = LVL_CLEAR;
        end else begin
            unique case (mode_i)
                MODE_NORMAL, MODE_SPARE: begin
                    state_d = above_thr ? LVL_SET : LVL_CLEAR;
                end
                MODE_HYST: begin
                    unique case (state_q)
                        LVL_CLEAR: begin
                            if (above_high) state_d = LVL_SET;
                        end
                        LVL_SET: begin
                            if (below_low)                   state_d = LVL_CLEAR;
                            else if (strobe_i && !above_high) state_d = LVL_CLEAR;
                        end
                        default: state_d = LVL_CLEAR;
                    endcase
                end
                MODE_WINDOW: begin
                    state_d = LVL_CLEAR;
                end
                default: state_d = LVL_CLEAR;
            endcase
        end
    end

    always_comb begin
        set_o = (state_q == LVL_SET);
    end

endmodule

// File: rtl/thresh_cmp_window_fsm.sv
`timescale 1ns/1ps
module thresh_cmp_window_fsm
    import thresh_cmp_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  cmp_mode_e         mode_i,
    input  logic              latch_en_i,
    input  logic              strobe_i,
    input  logic [CODE_W-1:0] sample_i,
    input  logic [CODE_W-1:0] high_i,
    input  logic [CODE_W-1:0] low_i,
    output logic              out_o
);

    win_state_e state_q, state_d;

    logic outside;
    assign outside = (sample_i > high_i) || (sample_i < low_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_INSIDE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (restart_i || mode_i != MODE_WINDOW) begin
            state_d = WIN_INSIDE;
        end else begin
            unique case (state_q)
                WIN_INSIDE, WIN_OUTSIDE: begin
                    if (!outside)        state_d = WIN_INSIDE;
                    else if (latch_en_i) state_d = WIN_HELD;
                    else                 state_d = WIN_OUTSIDE;
                end
                WIN_HELD: begin
                    if (!latch_en_i)                state_d = outside ? WIN_OUTSIDE : WIN_INSIDE;
                    else if (strobe_i && !outside)  state_d = WIN_INSIDE;
                    else                            state_d = WIN_HELD;
                end
                default: state_d = WIN_INSIDE;
            endcase
        end
    end

    always_comb begin
        out_o = (state_q != WIN_INSIDE);
    end

endmodule

// File: rtl/thresh_cmp_chan.sv
`timescale 1ns/1ps
module thresh_cmp_chan
    import thresh_cmp_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              flag_clr_i,
    input  logic [CODE_W-1:0] sample_i,
    output logic              cmp_pin_o,
    output logic              cmp_flag_o,
    output logic              win_stat_o
);

    cmp_cfg_t          cfg;
    logic [CODE_W-1:0] thr_code, high_code, low_code;
    logic              restart;
    logic              lvl_set, win_out;
    logic              raw_res;
    logic [1:0]        cur_mode;
    logic              out_en, win_latch;

    thresh_cmp_regs #(.CODE_W(CODE_W), .REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg),
        .thr_o     (thr_code),
        .high_o    (high_code),
        .low_o     (low_code),
        .restart_o (restart)
    );

    thresh_cmp_level_fsm #(.CODE_W(CODE_W)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .mode_i    (cfg.mode),
        .strobe_i  (flag_clr_i),
        .sample_i  (sample_i),
        .thr_i     (thr_code),
        .high_i    (high_code),
        .low_i     (low_code),
        .set_o     (lvl_set)
    );

    thresh_cmp_window_fsm #(.CODE_W(CODE_W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .mode_i     (cfg.mode),
        .latch_en_i (cfg.win_latch),
        .strobe_i   (flag_clr_i),
        .sample_i   (sample_i),
        .high_i     (high_code),
        .low_i      (low_code),
        .out_o      (win_out)
    );

    assign cur_mode  = cfg.mode;
    assign out_en    = cfg.out_en;
    assign win_latch = cfg.win_latch;

    always_comb begin
        raw_res    = (cfg.mode == MODE_WINDOW) ? win_out : lvl_set;
        cmp_flag_o = raw_res ^ cfg.invert;
        cmp_pin_o  = (cfg.out_en && cfg.mode != MODE_WINDOW) ? cmp_flag_o : 1'b0;
        win_stat_o = win_out;
    end

endmodule

// File: rtl/thresh_cmp_chan_chk.sv
`timescale 1ns/1ps
module thresh_cmp_chan_chk #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] sample,
    input logic [CODE_W-1:0] thr,
    input logic [CODE_W-1:0] high,
    input logic [CODE_W-1:0] low,
    input logic [1:0]        mode,
    input logic              out_en,
    input logic              win_latch,
    input logic              strobe,
    input logic              restart,
    input logic              raw_res,
    input logic              cmp_pin_o,
    input logic              win_stat_o
);

    // R8
    window_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b10 |-> !cmp_pin_o);

    // R4
    pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !cmp_pin_o);

    // R8
    win_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b10 |-> !win_stat_o);

    // R2
    normal_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !restart && sample == thr) |=> !raw_res);

    // R5
    hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !restart && !raw_res && !(sample > high)) |=> !raw_res);

    // R6
    latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !restart && raw_res && low == '0 && !strobe) |=> raw_res);

    // R7
    strobe_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !restart && strobe && sample > high) |=> raw_res);

    // R9
    win_latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !restart && win_latch && $past(win_latch) && win_stat_o && !strobe)
        |=> win_stat_o);

    // R10
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!raw_res && !win_stat_o));

endmodule

bind thresh_cmp_chan thresh_cmp_chan_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample     (sample_i),
    .thr        (thr_code),
    .high       (high_code),
    .low        (low_code),
    .mode       (cur_mode),
    .out_en     (out_en),
    .win_latch  (win_latch),
    .strobe     (flag_clr_i),
    .restart    (restart),
    .raw_res    (raw_res),
    .cmp_pin_o  (cmp_pin_o),
    .win_stat_o (win_stat_o)
);

// File: tb/test_thresh_cmp_chan.sv
`timescale 1ns/1ps
module test_thresh_cmp_chan;

    localparam int CODE_W = 12;
    localparam int REG_W  = 16;
    localparam int NV     = 57;
    localparam int WDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = '0;
    logic [REG_W-1:0]  wr_data = '0;
    logic              flag_clr = 1'b0;
    logic [CODE_W-1:0] sample = '0;
    logic              cmp_pin, cmp_flag, win_stat;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    thresh_cmp_chan #(.CODE_W(CODE_W), .REG_W(REG_W)) i_thresh_cmp_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .flag_clr_i (flag_clr),
        .sample_i   (sample),
        .cmp_pin_o  (cmp_pin),
        .cmp_flag_o (cmp_flag),
        .win_stat_o (win_stat)
    );

    // Entry: [38] write, [37:36] sel, [35:20] data, [19:8] sample,
    //        [7] strobe, [6:4] expected {flag,pin,win}, [3:0] requirement
    function automatic logic [38:0] W(logic [1:0] s, logic [15:0] d);
        return {1'b1, s, d, 12'd0, 1'b0, 3'd0, 4'd0};
    endfunction

    function automatic logic [38:0] S(int r, int smp, bit stb, logic [2:0] e);
        logic [31:0] rv = r;
        logic [31:0] sv = smp;
        return {1'b0, 2'd0, 16'd0, sv[11:0], stb, e, rv[3:0]};
    endfunction

    localparam logic [38:0] VEC [NV] = '{
        W(2'd0, 16'h0008), W(2'd1, 16'h4000),
        S(2, 1024, 0, 3'b000), S(2, 1025, 0, 3'b110),                                    // R2
        S(2, 2000, 0, 3'b110), S(2, 500, 0, 3'b000),                                     // R2
        W(2'd0, 16'h000C), S(3, 500, 0, 3'b110), S(3, 3000, 0, 3'b000),                  // R3
        W(2'd0, 16'h0004), S(4, 3000, 0, 3'b000), S(4, 100, 0, 3'b100),                  // R4
        W(2'd2, 16'hC000), W(2'd3, 16'h4000), W(2'd0, 16'h0009),
        S(5, 2000, 0, 3'b000), S(5, 3072, 0, 3'b000), S(5, 3073, 0, 3'b110),             // R5
        S(5, 2000, 0, 3'b110), S(5, 1024, 0, 3'b110), S(5, 1023, 0, 3'b000),             // R5
        S(5, 2000, 0, 3'b000),                                                           // R5
        S(7, 3500, 0, 3'b110), S(7, 2000, 1, 3'b000), S(7, 4000, 1, 3'b110),             // R7
        W(2'd3, 16'h0000),
        S(6, 0, 0, 3'b110), S(6, 2000, 1, 3'b000), S(6, 0, 0, 3'b000),                   // R6
        S(6, 3500, 0, 3'b110), S(6, 0, 0, 3'b110),                                       // R6
        W(2'd3, 16'h4000), W(2'd2, 16'hFFF0),
        S(6, 4095, 0, 3'b000), S(6, 4095, 1, 3'b000),                                    // R6
        W(2'd2, 16'hC000), W(2'd0, 16'h000A),
        S(8, 2000, 0, 3'b000), S(8, 3073, 0, 3'b101), S(8, 1023, 0, 3'b101),             // R8
        S(8, 1024, 0, 3'b000), S(8, 3072, 0, 3'b000),                                    // R8
        W(2'd0, 16'h001A),
        S(9, 3500, 0, 3'b101), S(9, 2000, 0, 3'b101), S(9, 2000, 1, 3'b000),             // R9
        S(9, 500, 0, 3'b101), S(9, 500, 1, 3'b101), S(9, 2000, 0, 3'b101),               // R9
        S(9, 2000, 1, 3'b000), S(9, 500, 0, 3'b101),                                     // R9
        W(2'd0, 16'h0019), S(10, 500, 0, 3'b000),                                        // R10
        W(2'd0, 16'h0008), W(2'd1, 16'h400F),
        S(11, 1024, 0, 3'b000), S(11, 1025, 0, 3'b110)                                   // R11
    };

    task automatic check(string req, logic [2:0] exp);
        logic [2:0] act;
        act = {cmp_flag, cmp_pin, win_stat};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {flag,pin,win} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state, while held and just after release
        repeat (3) @(negedge clk);
        check("R1", 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 3'b000);

        for (int i = 0; i < NV; i++) begin
            logic [38:0] v;
            v = VEC[i];
            if (v[38]) begin
                wr_en   = 1'b1;
                wr_sel  = v[37:36];
                wr_data = v[35:20];
                @(negedge clk);
                wr_en   = 1'b0;
            end else begin
                sample   = v[19:8];
                flag_clr = v[7];
                @(negedge clk);
                flag_clr = 1'b0;
                check($sformatf("R%0d", v[3:0]), v[6:4]);
            end
        end

        // R1: reset mid-run clears state and registers; output enable back to 0
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 3'b000);
        rst_n = 1'b1;
        sample = 12'd1025;
        @(negedge clk);
        check("R1", 3'b100);   // threshold 0 -> raw 1, pin gated off

        done = 1'b1;
        summary();
        $finish;
    end

endmodule